// File: doc/BRIEF.md
# Keyboard and ACPI Host Port Block

This block sits between a host I/O strobe bus and a local firmware core. It presents three host-visible channels. Each channel is a pair of byte ports: a data port and a command/status port. Channel 0 is the legacy keyboard-controller pair. Channels 1 and 2 are ACPI embedded-controller pairs. Every channel keeps an input buffer filled by the host and an output buffer filled by the firmware, along with status flags that both sides can see.

Host notifications are derived from channel state. Channel 0 pulses a legacy IRQ when it has fresh output data. The two ACPI channels request SCI, either merged onto one line (shared mode) or split so that channel 2 signals through SMI (private mode). The firmware drives fast Gate A20 and fast keyboard-reset lines through a control register. The firmware side is a small register bus addressed by channel and register number. Each channel has its own interrupt line, which stays high while the channel's input buffer is full.

Top module: `kbc_acpi_host_port`

## Requirements
- R1: After reset, all buffer-full, command, event and enable flags are clear, and host_irq, host_sci, host_smi, gate_a20, kbd_reset and core_irq are all low.
- R2: A host write to a channel's data address (0x60, 0x62, 0x68 for channels 0, 1, 2) or command address (0x64, 0x66, 0x6C) stores the byte in that channel's input buffer. It sets input-buffer-full (IBF) and core_irq[channel], and sets the command flag to 1 for the command address or 0 for the data address.
- R3: A core read of register 0 of a channel returns its input buffer and clears its IBF, which also drops core_irq for that channel.
- R4: A core write to register 1 of a channel loads its output buffer and sets output-buffer-full (OBF). A host read of the channel's data address returns that byte and clears OBF.
- R5: A host read of a command address returns the status byte: bit0 OBF, bit1 IBF, bit2 command flag, bit3 SCI event, bit4 SMI event, bits 7:5 zero. The read changes no state.
- R6: Channel 0 drives host_irq high for exactly one cycle after its OBF rises, but only when the IRQ enable bit (register 2 of channel 0, bit0) is 1. When that bit is 0, host_irq stays low.
- R7: Register 2 of each channel holds the SCI event flag (bit1) and the SMI event flag (bit2). For channels 1 and 2, the channel's SCI request is its OBF OR its SCI event flag.
- R8: In shared mode (register 3, bit0 = 0), host_sci is the OR of the SCI requests of channels 1 and 2. host_smi is the OR of the SMI event flags of all channels.
- R9: In private mode (register 3, bit0 = 1), channel 2's SCI request drives host_smi instead of host_sci. host_sci then follows channel 1 alone.
- R10: gate_a20 and kbd_reset follow register 3 bits 1 and 2 as last written by the core.
- R11: Host reads of any other address return 0xFF, and host writes to any other address change nothing.
- R12: If a host write and a core read of register 0 hit the same channel in the same cycle, IBF ends set and the buffer holds the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host I/O address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| core_sel | input | 2 | Core channel select (0..2; 3 = none) |
| core_reg | input | 2 | Core register: 0 input buffer, 1 output buffer/status, 2 channel control, 3 global control |
| core_wr | input | 1 | Core write strobe |
| core_rd | input | 1 | Core read strobe |
| core_wdata | input | 8 | Core write data |
| core_rdata | output | 8 | Core read data (combinational) |
| core_irq | output | 3 | Per-channel input-buffer-full interrupt |
| host_irq | output | 1 | Legacy keyboard IRQ pulse |
| host_sci | output | 1 | SCI request |
| host_smi | output | 1 | SMI request |
| gate_a20 | output | 1 | Fast Gate A20 |
| kbd_reset | output | 1 | Fast keyboard reset |

## Verification
The hardest case to reach is a host write landing in the same cycle as the firmware draining the same input buffer. Ordinary sequential tasks never overlap the two sides. The stimulus for this case drives both strobes from one task on one falling edge and checks afterwards that IBF stayed set with the new byte. A second awkward case is the one-cycle IRQ pulse. The bench samples host_irq on the two falling edges that follow the output-buffer write, then repeats the write with the enable cleared.

// File: rtl/kbc_acpi_host_port.sv
module kbc_acpi_host_port #(
  parameter logic [7:0] KBC_DATA = 8'h60,
  parameter logic [7:0] KBC_CMD  = 8'h64,
  parameter logic [7:0] PM1_DATA = 8'h62,
  parameter logic [7:0] PM1_CMD  = 8'h66,
  parameter logic [7:0] PM2_DATA = 8'h68,
  parameter logic [7:0] PM2_CMD  = 8'h6C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic [1:0] core_sel,
  input  logic [1:0] core_reg,
  input  logic       core_wr,
  input  logic       core_rd,
  input  logic [7:0] core_wdata,
  output logic [7:0] core_rdata,
  output logic [2:0] core_irq,
  output logic       host_irq,
  output logic       host_sci,
  output logic       host_smi,
  output logic       gate_a20,
  output logic       kbd_reset
);
  localparam int NCH = 3;

  logic [7:0] ib [NCH];
  logic [7:0] ob [NCH];
  logic [NCH-1:0] ibf, obf, cmdf, sci_evt, smi_evt;
  logic irq_en, priv, kbc_obf_d;
  logic [NCH-1:0] hit_d, hit_c;
  logic [7:0] stat [NCH];

  assign hit_d = {host_addr == PM2_DATA, host_addr == PM1_DATA, host_addr == KBC_DATA};
  assign hit_c = {host_addr == PM2_CMD,  host_addr == PM1_CMD,  host_addr == KBC_CMD};

  for (genvar g = 0; g < NCH; g++) begin : g_stat
    assign stat[g] = {3'b000, smi_evt[g], sci_evt[g], cmdf[g], ibf[g], obf[g]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ib[i] <= '0;
        ob[i] <= '0;
      end
      ibf <= '0; obf <= '0; cmdf <= '0; sci_evt <= '0; smi_evt <= '0;
      irq_en <= 1'b0; priv <= 1'b0; gate_a20 <= 1'b0; kbd_reset <= 1'b0;
      kbc_obf_d <= 1'b0;
    end else begin
      kbc_obf_d <= obf[0];
      for (int i = 0; i < NCH; i++) begin
        if (core_wr && core_sel == 2'(i) && core_reg == 2'd1) begin
          ob[i]  <= core_wdata;
          obf[i] <= 1'b1;
        end else if (host_rd && hit_d[i]) begin
          obf[i] <= 1'b0;
        end
        if (host_wr && (hit_d[i] || hit_c[i])) begin
          ib[i]   <= host_wdata;
          ibf[i]  <= 1'b1;
          cmdf[i] <= hit_c[i];
        end else if (core_rd && core_sel == 2'(i) && core_reg == 2'd0) begin
          ibf[i] <= 1'b0;
        end
        if (core_wr && core_sel == 2'(i) && core_reg == 2'd2) begin
          sci_evt[i] <= core_wdata[1];
          smi_evt[i] <= core_wdata[2];
          if (i == 0) irq_en <= core_wdata[0];
        end
      end
      if (core_wr && core_reg == 2'd3) begin
        priv      <= core_wdata[0];
        gate_a20  <= core_wdata[1];
        kbd_reset <= core_wdata[2];
      end
    end
  end

  always_comb begin
    host_rdata = 8'hFF;
    for (int i = 0; i < NCH; i++) begin
      if (hit_d[i]) host_rdata = ob[i];
      if (hit_c[i]) host_rdata = stat[i];
    end
  end

  always_comb begin
    core_rdata = 8'h00;
    if (core_reg == 2'd3) core_rdata = {5'b0, kbd_reset, gate_a20, priv};
    else if (core_sel != 2'd3) begin
      case (core_reg)
        2'd0:    core_rdata = ib[core_sel];
        2'd1:    core_rdata = stat[core_sel];
        default: core_rdata = {5'b0, smi_evt[core_sel], sci_evt[core_sel],
                               (core_sel == 2'd0) ? irq_en : 1'b0};
      endcase
    end
  end

  logic [2:1] sci_req;
  assign sci_req  = obf[2:1] | sci_evt[2:1];
  assign core_irq = ibf;
  assign host_irq = irq_en & obf[0] & ~kbc_obf_d;
  assign host_sci = sci_req[1] | (~priv & sci_req[2]);
  assign host_smi = (|smi_evt) | (priv & sci_req[2]);

  a_r2_ibf_set: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && (hit_d[0] || hit_c[0]) |=> core_irq[0]);
  a_r3_ibf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    core_rd && core_sel == 2'd0 && core_reg == 2'd0 && !host_wr |=> !core_irq[0]);
  a_r4_obf_set: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr && core_sel == 2'd1 && core_reg == 2'd1 |=> obf[1]);
  a_r5_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && hit_c[0] && !host_wr && !core_wr && !core_rd |=> $stable(obf) && $stable(ibf));
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);
  a_r12_collide: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && hit_d[1] && core_rd && core_sel == 2'd1 && core_reg == 2'd0 |=> core_irq[1]);
endmodule

// File: tb/test_kbc_acpi_host_port.sv
module test_kbc_acpi_host_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0, core_wdata = '0;
  logic host_wr = 1'b0, host_rd = 1'b0, core_wr = 1'b0, core_rd = 1'b0;
  logic [1:0] core_sel = 2'd3, core_reg = '0;
  logic [7:0] host_rdata, core_rdata;
  logic [2:0] core_irq;
  logic host_irq, host_sci, host_smi, gate_a20, kbd_reset;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  kbc_acpi_host_port i_kbc_acpi_host_port (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hrd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1; #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic cwr(logic [1:0] s, logic [1:0] r, logic [7:0] d);
    @(negedge clk); core_sel = s; core_reg = r; core_wdata = d; core_wr = 1'b1;
    @(negedge clk); core_wr = 1'b0; core_sel = 2'd3;
  endtask

  task automatic crd(logic [1:0] s, logic [1:0] r, output logic [7:0] d);
    @(negedge clk); core_sel = s; core_reg = r; core_rd = 1'b1; #1 d = core_rdata;
    @(negedge clk); core_rd = 1'b0; core_sel = 2'd3;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 core_irq", core_irq, 0);
    chk("R1 notify", {host_irq, host_sci, host_smi, gate_a20, kbd_reset}, 0);
    hrd(8'h64, d); chk("R1 kbc status", d, 8'h00);
  endtask

  task automatic t_write;
    logic [7:0] d;
    hwr(8'h64, 8'hD1);
    chk("R2 core_irq cmd", core_irq, 3'b001);
    hrd(8'h64, d); chk("R2 status cmd", d, 8'h06);
    crd(2'd0, 2'd0, d); chk("R3 ib value", d, 8'hD1);
    chk("R3 ibf cleared", core_irq, 3'b000);
    hwr(8'h68, 8'h3C);
    hrd(8'h6C, d); chk("R2 status data", d, 8'h02);
    crd(2'd2, 2'd0, d); chk("R3 ib pm2", d, 8'h3C);
  endtask

  task automatic t_obuf;
    logic [7:0] d;
    cwr(2'd1, 2'd1, 8'hA5);
    hrd(8'h66, d); chk("R5 status obf", d, 8'h01);
    hrd(8'h66, d); chk("R5 status no side effect", d, 8'h01);
    hrd(8'h62, d); chk("R4 ob value", d, 8'hA5);
    hrd(8'h66, d); chk("R4 obf cleared", d, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    cwr(2'd0, 2'd2, 8'h01);
    @(negedge clk); core_sel = 2'd0; core_reg = 2'd1; core_wdata = 8'h55; core_wr = 1'b1;
    @(negedge clk); core_wr = 1'b0; core_sel = 2'd3;
    chk("R6 irq pulse high", host_irq, 1'b1);
    @(negedge clk); chk("R6 irq pulse ends", host_irq, 1'b0);
    hrd(8'h60, d);
    cwr(2'd0, 2'd2, 8'h00);
    @(negedge clk); core_sel = 2'd0; core_reg = 2'd1; core_wdata = 8'h66; core_wr = 1'b1;
    @(negedge clk); core_wr = 1'b0; core_sel = 2'd3;
    chk("R6 irq disabled", host_irq, 1'b0);
    hrd(8'h60, d);
  endtask

  task automatic t_shared;
    logic [7:0] d;
    cwr(2'd1, 2'd2, 8'h02);
    chk("R7 sci from event", host_sci, 1'b1);
    hrd(8'h66, d); chk("R7 status sci flag", d, 8'h08);
    cwr(2'd1, 2'd2, 8'h00);
    cwr(2'd2, 2'd1, 8'h11);
    chk("R8 shared sci from pm2", {host_sci, host_smi}, 2'b10);
    cwr(2'd0, 2'd2, 8'h04);
    chk("R8 smi from event", host_smi, 1'b1);
    cwr(2'd0, 2'd2, 8'h00);
  endtask

  task automatic t_private;
    logic [7:0] d;
    cwr(2'd3, 2'd3, 8'h01);
    chk("R9 private pm2 to smi", {host_sci, host_smi}, 2'b01);
    hrd(8'h68, d);
    chk("R9 pm2 drained", {host_sci, host_smi}, 2'b00);
    cwr(2'd1, 2'd1, 8'h22);
    chk("R9 pm1 still sci", {host_sci, host_smi}, 2'b10);
    hrd(8'h62, d);
    cwr(2'd3, 2'd3, 8'h00);
  endtask

  task automatic t_gate;
    cwr(2'd3, 2'd3, 8'h02);
    chk("R10 a20 set", {gate_a20, kbd_reset}, 2'b10);
    cwr(2'd3, 2'd3, 8'h04);
    chk("R10 reset set", {gate_a20, kbd_reset}, 2'b01);
    cwr(2'd3, 2'd3, 8'h00);
    chk("R10 cleared", {gate_a20, kbd_reset}, 2'b00);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    hrd(8'h61, d); chk("R11 unmapped read", d, 8'hFF);
    hwr(8'h65, 8'h99);
    chk("R11 unmapped write ignored", core_irq, 3'b000);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    hwr(8'h62, 8'h10);
    @(negedge clk);
    host_addr = 8'h62; host_wdata = 8'h20; host_wr = 1'b1;
    core_sel = 2'd1; core_reg = 2'd0; core_rd = 1'b1;
    @(negedge clk); host_wr = 1'b0; core_rd = 1'b0; core_sel = 2'd3;
    chk("R12 ibf kept", core_irq, 3'b010);
    crd(2'd1, 2'd0, d); chk("R12 new byte", d, 8'h20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_write; t_obuf; t_irq; t_shared; t_private; t_gate; t_unmapped; t_collide;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule